// File: doc/BRIEF.md
# Power Intent Runtime Checker

This block is a passive monitor that sits beside the power controller of a chip region made of one always-present top-level domain and several switchable child domains. For each domain it watches five control indications: supply present, clock running, isolation enable, and the retention save and restore pulses. It also watches a per-domain strobe that marks a change of operating condition. It reports violations of the power intent on sticky flags, one flag per rule. A separate register captures the lowest-numbered domain that failed in the first violating cycle.

The rules cover four areas. The first is the clock being left running in a domain that has lost supply; this is sampled only at operating-condition strobes. The second is the save/restore command order of the retention logic, reduced to missing and overlapping commands. The third is isolation not being asserted while a domain is off. The fourth is a child domain being powered while the top-level domain is not. A synchronous clear empties all flags and the captured index. Software or a test harness polls the flags and the index after a power sequence.

Top module: `pic_power_intent_chk`

## Requirements
- R1: After reset every violation flag is 0 and `first_vld` is 0. Bit d of every per-domain vector belongs to domain d. Domain 0 is the top-level domain and domains 1 to 5 are its children.
- R2: `viol_clk` is set in the cycle after a cycle in which `opc_chg[d]`=1, `pwr_ok[d]`=0 and `clk_run[d]`=1. The same supply/clock condition without the strobe sets nothing, and a strobe while powered sets nothing.
- R3: A restore pulse on a powered domain with no save recorded since its last restore sets `viol_ret_miss` one cycle later.
- R4: A falling edge of `pwr_ok[d]` with no save recorded sets `viol_ret_miss` only if bit d of parameter RET_MASK is 1. The default mask is 6'b011110, so domains 1 to 4 need retention and domains 0 and 5 do not.
- R5: `viol_ret_ovl` is set one cycle after any of these: a save while a save is already recorded, a save or restore while the domain is unpowered, or a save and restore in the same cycle.
- R6: The sequence save, power off with isolation on, power on, release isolation, restore sets no flag.
- R7: A domain with `pwr_ok[d]`=0 and `iso_en[d]`=0 sets `viol_iso` one cycle later. Isolation asserted while powered sets nothing.
- R8: Any child domain with `pwr_ok` high while `pwr_ok[0]` is low sets `viol_order` one cycle later. An unpowered child under a powered top sets nothing.
- R9: Flags stay set until `clr` is high at a clock edge. That edge leaves all flags and `first_vld` at 0, and clear wins over violations of the same cycle.
- R10: On the first violating cycle after reset or clear, `first_vld` rises and `first_dom` takes the lowest index among the domains failing in that cycle. Both hold, unchanged by later violations, until clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of flags and captured index |
| pwr_ok | input | NUM_DOM | Supply present, one bit per domain |
| clk_run | input | NUM_DOM | Clock running, one bit per domain |
| iso_en | input | NUM_DOM | Isolation enable, one bit per domain |
| ret_save | input | NUM_DOM | Retention save pulse |
| ret_restore | input | NUM_DOM | Retention restore pulse |
| opc_chg | input | NUM_DOM | Operating-condition change strobe |
| viol_clk | output | 1 | Clock running while unpowered, seen at a strobe |
| viol_ret_miss | output | 1 | Missing retention save |
| viol_ret_ovl | output | 1 | Overlapping or misplaced retention command |
| viol_iso | output | 1 | Isolation off in an unpowered domain |
| viol_order | output | 1 | Child powered under an unpowered top domain |
| first_vld | output | 1 | A violation has been captured |
| first_dom | output | $clog2(NUM_DOM) | Lowest failing domain of the first violating cycle |

## Verification
The bench holds the clock-running-while-off condition for a cycle without a strobe. A checker that sampled that rule every cycle would raise `viol_clk` too early. It drives a legal retention round trip across a power cycle, where a design that dropped the recorded save at power-off would report a missing save on restore. It also drives a same-cycle save and restore, and a save while off, which a checker testing only for a double save would miss. Two domains fail together and a lower-numbered one fails later, so the test catches an index that does not pick the lowest bit or that is overwritten afterwards. Powering off a domain whose mask bit is clear and clearing during an active violation complete the set.

// File: rtl/pic_pkg.sv
package pic_pkg;

  localparam int NUM_RULES = 5;
  localparam int RULE_CLK  = 0;
  localparam int RULE_MISS = 1;
  localparam int RULE_OVL  = 2;
  localparam int RULE_ISO  = 3;
  localparam int RULE_ORD  = 4;

  // Index of the lowest set bit; 0 when none is set.
  function automatic int unsigned lowest_set(input logic [31:0] vec);
    int unsigned idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (vec[i]) idx = i;
    end
    return idx;
  endfunction

  // Retention command placed where it does not belong.
  function automatic logic ret_overlap(input logic save, input logic restore,
                                       input logic stored, input logic pwr);
    return (save & (stored | ~pwr)) | (save & restore) | (restore & ~pwr);
  endfunction

  // Restore with nothing stored, or supply lost with nothing stored.
  function automatic logic ret_missing(input logic save, input logic restore,
                                       input logic stored, input logic pwr,
                                       input logic pwr_fall, input logic needed);
    return (restore & pwr & ~save & ~stored) | (pwr_fall & ~stored & needed);
  endfunction

endpackage

// File: rtl/pic_dom_track.sv
module pic_dom_track
  import pic_pkg::*;
#(
  parameter bit IS_CHILD = 1'b1,
  parameter bit RET_REQ  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr,
  input  logic top_pwr,
  input  logic clk_on,
  input  logic iso,
  input  logic save,
  input  logic restore,
  input  logic opc,
  output logic ev_clk,
  output logic ev_miss,
  output logic ev_ovl,
  output logic ev_iso,
  output logic ev_ord,
  output logic stored
);

  logic pwr_q;
  logic pwr_fall;

  assign pwr_fall = pwr_q & ~pwr;

  assign ev_clk  = opc & ~pwr & clk_on;
  assign ev_ovl  = ret_overlap(save, restore, stored, pwr);
  assign ev_miss = ret_missing(save, restore, stored, pwr, pwr_fall, RET_REQ);
  assign ev_iso  = ~pwr & ~iso;
  assign ev_ord  = IS_CHILD ? (pwr & ~top_pwr) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      stored <= 1'b0;
    end else begin
      pwr_q <= pwr;
      if (save && !restore && pwr)      stored <= 1'b1;
      else if (restore && !save && pwr) stored <= 1'b0;
    end
  end

endmodule

// File: rtl/pic_flag_latch.sv
module pic_flag_latch
  import pic_pkg::*;
#(
  parameter int NR    = 5,
  parameter int ND    = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [NR-1:0]    rule_hit,
  input  logic [ND-1:0]    dom_hit,
  output logic [NR-1:0]    flags,
  output logic             first_vld,
  output logic [IDX_W-1:0] first_dom
);

  logic capture;

  assign capture = !first_vld && (|dom_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags     <= '0;
      first_vld <= 1'b0;
      first_dom <= '0;
    end else if (clr) begin
      flags     <= '0;
      first_vld <= 1'b0;
      first_dom <= '0;
    end else begin
      flags <= flags | rule_hit;
      if (capture) begin
        first_vld <= 1'b1;
        first_dom <= IDX_W'(lowest_set(32'(dom_hit)));
      end
    end
  end

endmodule

// File: rtl/pic_power_intent_chk.sv
module pic_power_intent_chk
  import pic_pkg::*;
#(
  parameter int                 NUM_DOM  = 6,
  parameter logic [NUM_DOM-1:0] RET_MASK = 6'b011110,
  localparam int                IDX_W    = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [NUM_DOM-1:0] pwr_ok,
  input  logic [NUM_DOM-1:0] clk_run,
  input  logic [NUM_DOM-1:0] iso_en,
  input  logic [NUM_DOM-1:0] ret_save,
  input  logic [NUM_DOM-1:0] ret_restore,
  input  logic [NUM_DOM-1:0] opc_chg,
  output logic               viol_clk,
  output logic               viol_ret_miss,
  output logic               viol_ret_ovl,
  output logic               viol_iso,
  output logic               viol_order,
  output logic               first_vld,
  output logic [IDX_W-1:0]   first_dom
);

  logic [NUM_DOM-1:0]   ev_clk, ev_miss, ev_ovl, ev_iso, ev_ord;
  logic [NUM_DOM-1:0]   ret_saved;
  logic [NUM_DOM-1:0]   dom_hit;
  logic [NUM_RULES-1:0] rule_hit;
  logic [NUM_RULES-1:0] flags;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    pic_dom_track #(
      .IS_CHILD (d != 0),
      .RET_REQ  (RET_MASK[d])
    ) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr     (pwr_ok[d]),
      .top_pwr (pwr_ok[0]),
      .clk_on  (clk_run[d]),
      .iso     (iso_en[d]),
      .save    (ret_save[d]),
      .restore (ret_restore[d]),
      .opc     (opc_chg[d]),
      .ev_clk  (ev_clk[d]),
      .ev_miss (ev_miss[d]),
      .ev_ovl  (ev_ovl[d]),
      .ev_iso  (ev_iso[d]),
      .ev_ord  (ev_ord[d]),
      .stored  (ret_saved[d])
    );
  end

  assign dom_hit = ev_clk | ev_miss | ev_ovl | ev_iso | ev_ord;

  always_comb begin
    rule_hit            = '0;
    rule_hit[RULE_CLK]  = |ev_clk;
    rule_hit[RULE_MISS] = |ev_miss;
    rule_hit[RULE_OVL]  = |ev_ovl;
    rule_hit[RULE_ISO]  = |ev_iso;
    rule_hit[RULE_ORD]  = |ev_ord;
  end

  pic_flag_latch #(
    .NR    (NUM_RULES),
    .ND    (NUM_DOM),
    .IDX_W (IDX_W)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .rule_hit  (rule_hit),
    .dom_hit   (dom_hit),
    .flags     (flags),
    .first_vld (first_vld),
    .first_dom (first_dom)
  );

  assign viol_clk      = flags[RULE_CLK];
  assign viol_ret_miss = flags[RULE_MISS];
  assign viol_ret_ovl  = flags[RULE_OVL];
  assign viol_iso      = flags[RULE_ISO];
  assign viol_order    = flags[RULE_ORD];

endmodule

// File: rtl/pic_chk_sva.sv
module pic_chk_sva #(
  parameter int ND = 6,
  localparam int IW = (ND > 1) ? $clog2(ND) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic [ND-1:0] pwr_ok,
  input logic [ND-1:0] clk_run,
  input logic [ND-1:0] iso_en,
  input logic [ND-1:0] ret_save,
  input logic [ND-1:0] ret_restore,
  input logic [ND-1:0] opc_chg,
  input logic [ND-1:0] ret_saved,
  input logic          viol_clk,
  input logic          viol_ret_miss,
  input logic          viol_ret_ovl,
  input logic          viol_iso,
  input logic          viol_order,
  input logic          first_vld,
  input logic [IW-1:0] first_dom
);

  logic [4:0] fl;
  assign fl = {viol_order, viol_iso, viol_ret_ovl, viol_ret_miss, viol_clk};

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fl == 5'b0) && !first_vld); // R9

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((fl & $past(fl)) == $past(fl))); // R9

  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (first_vld && !clr) |=> first_vld && $stable(first_dom)); // R10

  AST_FIRST_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    first_vld |-> (fl != 5'b0)); // R10

  AST_CLK_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && |(opc_chg & ~pwr_ok & clk_run)) |=> viol_clk); // R2

  AST_MISS_UNSAVED: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && |(ret_restore & pwr_ok & ~ret_save & ~ret_saved)) |=> viol_ret_miss); // R3

  AST_ISO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && |(~pwr_ok & ~iso_en)) |=> viol_iso); // R7

  AST_CHILD_UNDER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !pwr_ok[0] && |pwr_ok[ND-1:1]) |=> viol_order); // R8

endmodule

bind pic_power_intent_chk pic_chk_sva #(.ND(NUM_DOM)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clr           (clr),
  .pwr_ok        (pwr_ok),
  .clk_run       (clk_run),
  .iso_en        (iso_en),
  .ret_save      (ret_save),
  .ret_restore   (ret_restore),
  .opc_chg       (opc_chg),
  .ret_saved     (ret_saved),
  .viol_clk      (viol_clk),
  .viol_ret_miss (viol_ret_miss),
  .viol_ret_ovl  (viol_ret_ovl),
  .viol_iso      (viol_iso),
  .viol_order    (viol_order),
  .first_vld     (first_vld),
  .first_dom     (first_dom)
);

// File: tb/test_pic_power_intent_chk.sv
module test_pic_power_intent_chk;

  localparam int CLK_PERIOD = 10;
  localparam int ND = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic [ND-1:0] pwr_ok, clk_run, iso_en, ret_save, ret_restore, opc_chg;
  logic viol_clk, viol_ret_miss, viol_ret_ovl, viol_iso, viol_order, first_vld;
  logic [2:0] first_dom;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_power_intent_chk i_pic_power_intent_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .pwr_ok(pwr_ok), .clk_run(clk_run), .iso_en(iso_en),
    .ret_save(ret_save), .ret_restore(ret_restore), .opc_chg(opc_chg),
    .viol_clk(viol_clk), .viol_ret_miss(viol_ret_miss), .viol_ret_ovl(viol_ret_ovl),
    .viol_iso(viol_iso), .viol_order(viol_order),
    .first_vld(first_vld), .first_dom(first_dom)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected flags packed as {clk, miss, ovl, iso, order}
  task automatic chk_flags(string req, logic [4:0] exp);
    chk(req, "flags{clk,miss,ovl,iso,ord}",
        int'({viol_clk, viol_ret_miss, viol_ret_ovl, viol_iso, viol_order}), int'(exp));
  endtask

  task automatic do_clear();
    clr = 1'b1; step(); clr = 1'b0;
  endtask

  task automatic t_reset();
    chk_flags("R1", 5'b00000);
    chk("R1", "first_vld", first_vld, 0);
  endtask

  task automatic t_clk_rule();
    opc_chg[2] = 1'b1; step(); opc_chg = '0;
    chk_flags("R2 strobe while powered", 5'b00000);
    ret_save[2] = 1'b1; step(); ret_save = '0;
    pwr_ok[2] = 1'b0; iso_en[2] = 1'b1; step();
    chk_flags("R2 no strobe", 5'b00000);
    opc_chg[2] = 1'b1; step(); opc_chg = '0;
    chk_flags("R2", 5'b10000);
    chk("R10", "first_dom", first_dom, 2);
    step();
    chk_flags("R9 sticky", 5'b10000);
    pwr_ok[2] = 1'b1; step();
    iso_en[2] = 1'b0; ret_restore[2] = 1'b1; step(); ret_restore = '0;
    chk_flags("R6 restore after save", 5'b10000);
    do_clear();
    chk_flags("R9 clear", 5'b00000);
    chk("R9", "first_vld", first_vld, 0);
  endtask

  task automatic t_ret_ok();
    ret_save[3] = 1'b1; step(); ret_save = '0;
    pwr_ok[3] = 1'b0; iso_en[3] = 1'b1; step();
    step();
    pwr_ok[3] = 1'b1; step();
    iso_en[3] = 1'b0; ret_restore[3] = 1'b1; step(); ret_restore = '0;
    chk_flags("R6", 5'b00000);
    chk("R6", "first_vld", first_vld, 0);
  endtask

  task automatic t_miss_restore();
    ret_restore[1] = 1'b1; step(); ret_restore = '0;
    chk_flags("R3", 5'b01000);
    chk("R3", "first_dom", first_dom, 1);
    do_clear();
  endtask

  task automatic t_miss_off();
    pwr_ok[4] = 1'b0; iso_en[4] = 1'b1; step();
    chk_flags("R4 mask set", 5'b01000);
    pwr_ok[4] = 1'b1; step(); iso_en[4] = 1'b0; step();
    do_clear();
    pwr_ok[5] = 1'b0; iso_en[5] = 1'b1; step();
    chk_flags("R4 mask clear", 5'b00000);
    pwr_ok[5] = 1'b1; step(); iso_en[5] = 1'b0; step();
    chk_flags("R4 mask clear after power-up", 5'b00000);
  endtask

  task automatic t_overlap();
    ret_save[2] = 1'b1; step(); step();
    ret_save = '0;
    chk_flags("R5 double save", 5'b00100);
    ret_restore[2] = 1'b1; step(); ret_restore = '0;
    do_clear();
    ret_save[3] = 1'b1; ret_restore[3] = 1'b1; step();
    ret_save = '0; ret_restore = '0;
    chk_flags("R5 save and restore together", 5'b00100);
    do_clear();
    ret_save[1] = 1'b1; step(); ret_save = '0;
    pwr_ok[1] = 1'b0; iso_en[1] = 1'b1; step();
    chk_flags("R5 precheck", 5'b00000);
    ret_save[1] = 1'b1; step(); ret_save = '0;
    chk_flags("R5 save while off", 5'b00100);
    pwr_ok[1] = 1'b1; step(); iso_en[1] = 1'b0;
    ret_restore[1] = 1'b1; step(); ret_restore = '0;
    do_clear();
    chk_flags("R9 clear after R5", 5'b00000);
  endtask

  task automatic t_iso();
    iso_en[5] = 1'b1; step();
    chk_flags("R7 iso while on", 5'b00000);
    pwr_ok[5] = 1'b0; iso_en[5] = 1'b0; step();
    chk_flags("R7", 5'b00010);
    chk("R7", "first_dom", first_dom, 5);
    pwr_ok[5] = 1'b1; step();
    do_clear();
  endtask

  task automatic t_first();
    ret_save[2] = 1'b1; ret_save[4] = 1'b1; step(); ret_save = '0;
    pwr_ok[2] = 1'b0; pwr_ok[4] = 1'b0; step();
    chk("R10 two domains", "first_dom", first_dom, 2);
    chk("R10", "first_vld", first_vld, 1);
    iso_en[2] = 1'b1; iso_en[4] = 1'b1;
    ret_restore[1] = 1'b1; step(); ret_restore = '0;
    chk("R10 later lower domain", "first_dom", first_dom, 2);
    chk("R3 dom1", "viol_ret_miss", viol_ret_miss, 1);
    pwr_ok[2] = 1'b1; pwr_ok[4] = 1'b1; step();
    iso_en = '0; ret_restore[2] = 1'b1; ret_restore[4] = 1'b1; step();
    ret_restore = '0;
    do_clear();
    chk_flags("R9 clear after R10", 5'b00000);
  endtask

  task automatic t_order();
    pwr_ok[5] = 1'b0; iso_en[5] = 1'b1; step();
    chk_flags("R8 child off under powered top", 5'b00000);
    pwr_ok[5] = 1'b1; step(); iso_en[5] = 1'b0; step();
    pwr_ok[0] = 1'b0; iso_en[0] = 1'b1; step();
    chk_flags("R8", 5'b00001);
    chk("R8", "first_dom", first_dom, 1);
    clr = 1'b1; step(); clr = 1'b0;
    chk_flags("R9 clear wins", 5'b00000);
    step();
    chk_flags("R9 re-flag after clear", 5'b00001);
    pwr_ok[0] = 1'b1; step(); iso_en[0] = 1'b0; step();
    do_clear();
  endtask

  initial begin
    pwr_ok = '1; clk_run = '1; iso_en = '0;
    ret_save = '0; ret_restore = '0; opc_chg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_clk_rule();
    t_ret_ok();
    t_miss_restore();
    t_miss_off();
    t_overlap();
    t_iso();
    t_first();
    t_order();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule